// File: doc/BRIEF.md
# Serial audio receive slot controller

This block is the receive side of a frame-synchronised serial port. The bit clock, frame sync and serial data arrive synchronous to the system clock. The block finds each falling bit-clock edge and samples the data line there, most significant bit first. Each time a full word has been assembled, the word goes into an eight-entry receive FIFO. The host takes words out of the FIFO through a read strobe and a read-data register.

Two slot disciplines are supported. In normal mode, only a slot that begins with the frame sync is captured, and the port then goes idle. In network mode, every slot after a frame sync is captured back to back, and a frame-sync flag marks slot zero. The block also provides two outputs. A watermark flag reports that the stored word count has reached a programmed level, and an interrupt output is that flag gated by an enable.

The slot state machine has two states. IDLE waits for a falling edge with frame sync high and moves to SHIFT. SHIFT shifts bits. On a sync edge it restarts the slot and stays in SHIFT. When the last bit of a slot arrives, it pushes the word and then returns to IDLE in normal mode, or stays in SHIFT in network mode to take the next slot. Dropping the port enable forces IDLE from either state.

Top module: `srx_slot_ctrl`

## Requirements
- R1: After reset, `rd_data`, `rfs_flag`, `rff_flag` and `rx_irq` are all 0.
- R2: Data is sampled on each falling edge of `bclk`, MSB first. After `WORD_W` (16) samples, the assembled word is stored, and a later read returns it on `rd_data`.
- R3: In normal mode, bits arriving while no slot is open are ignored. After one slot is captured, the following slot without a sync is not stored.
- R4: In network mode, every consecutive slot following a frame sync is stored, in arrival order.
- R5: `rfs_flag` goes to 1 at the falling edge that samples a frame sync. In network mode, it goes to 0 at the first bit of the next slot that begins without a sync.
- R6: `rff_flag` equals 1 exactly when the stored count is at least `rx_wm`. An `rx_wm` of 0 acts as 1, and values above 8 never raise the flag.
- R7: Host reads lower the stored count, and `rff_flag` clears once the count falls below the watermark.
- R8: With 8 words stored, further completed words are discarded, and the 8 stored words read back unchanged.
- R9: A read with the FIFO empty leaves `rd_data` at its previous value and leaves the count at zero.
- R10: `rx_irq` equals `rff_flag` AND `rx_irq_en`.
- R11: With `port_en` low, the FIFO is emptied, `rff_flag` and `rfs_flag` read 0, and the state machine returns to IDLE. `rd_data` keeps its value.
- R12: A frame sync seen part-way through a slot abandons the partial word and starts a new slot with that bit as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable; low flushes and idles the receiver |
| net_mode | input | 1 | 1 = network mode, 0 = normal mode |
| rx_wm | input | 4 | Receive watermark level (1..8) |
| rx_irq_en | input | 1 | Receive interrupt enable |
| bclk | input | 1 | Bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled with the first bit of a slot |
| sdin | input | 1 | Serial data in |
| rd_en | input | 1 | One-cycle read strobe for the receive data register |
| rd_data | output | 16 | Receive data register |
| rfs_flag | output | 1 | Frame sync seen on the current or last slot |
| rff_flag | output | 1 | Stored count has reached the watermark |
| rx_irq | output | 1 | Gated receive interrupt |

## Verification
The assertions assume that `bclk`, `fsync` and `sdin` are already synchronous to `clk`. They also assume that each bit-clock phase lasts at least one system clock, so that every falling edge is seen as one single-cycle event. They further assume that `rd_en` is a one-cycle strobe. The bench drives each bit-clock phase for two system clocks, holding sync and data steady across the falling edge. It changes every input at the falling edge of the system clock and reads the outputs two cycles after the last bit of a word.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } srx_state_e;
endpackage

// File: rtl/srx_word_fifo.sv
module srx_word_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] rdata,
    output logic [CW-1:0]     count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              do_push, do_pop;

    assign do_push = push && (count != FULL_CNT);
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            rdata <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_IX) ? '0 : wptr + 1'b1;
            if (do_pop) begin
                rdata <= mem[rptr];
                rptr  <= (rptr == LAST_IX) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: stored count never exceeds the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R8: a word arriving while full is discarded
    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop && !flush) |=> (count == FULL_CNT));

    // R9: reading an empty FIFO keeps the register and count
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push) |=> ($stable(rdata) && count == '0));
endmodule

// File: rtl/srx_slot_fsm.sv
module srx_slot_fsm
    import srx_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNTW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              net_mode,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              sdin,
    output logic              push,
    output logic [WORD_W-1:0] word,
    output logic              rfs
);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(WORD_W - 1);

    srx_state_e        state, state_nx;
    logic              bclk_q, fall;
    logic [CNTW-1:0]   bitcnt;
    logic [WORD_W-1:0] shreg;

    assign fall = bclk_q && !bclk;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else if (fall) begin
            unique case (state)
                ST_IDLE:  if (fsync) state_nx = ST_SHIFT;
                ST_SHIFT: begin
                    if (!fsync && bitcnt == LAST_BIT && !net_mode)
                        state_nx = ST_IDLE;
                end
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign push = en && fall && (state == ST_SHIFT) && !fsync && (bitcnt == LAST_BIT);
    assign word = {shreg[WORD_W-2:0], sdin};

    // datapath and flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            bitcnt <= '0;
            shreg  <= '0;
            rfs    <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (!en) begin
                bitcnt <= '0;
                rfs    <= 1'b0;
            end else if (fall) begin
                if (fsync) begin
                    bitcnt <= CNTW'(1);
                    shreg  <= {shreg[WORD_W-2:0], sdin};
                    rfs    <= 1'b1;
                end else if (state == ST_SHIFT) begin
                    if (bitcnt == '0) rfs <= 1'b0;
                    bitcnt <= (bitcnt == LAST_BIT) ? '0 : bitcnt + 1'b1;
                    shreg  <= {shreg[WORD_W-2:0], sdin};
                end
            end
        end
    end

    // R5: a sampled sync raises the frame-sync flag
    a_r5_rfs_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fall && fsync) |=> rfs);

    // R11: disable returns the machine to idle
    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !rfs));

    // R3: no word is produced from the idle state
    a_r3_no_idle_push: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !push);
endmodule

// File: rtl/srx_slot_ctrl.sv
module srx_slot_ctrl #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              net_mode,
    input  logic [CW-1:0]     rx_wm,
    input  logic              rx_irq_en,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              sdin,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rfs_flag,
    output logic              rff_flag,
    output logic              rx_irq
);
    logic              push;
    logic [WORD_W-1:0] word;
    logic [CW-1:0]     count;
    logic [CW-1:0]     wm_eff;

    srx_slot_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (port_en),
        .net_mode (net_mode),
        .bclk     (bclk),
        .fsync    (fsync),
        .sdin     (sdin),
        .push     (push),
        .word     (word),
        .rfs      (rfs_flag)
    );

    srx_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!port_en),
        .push  (push),
        .wdata (word),
        .pop   (rd_en && port_en),
        .rdata (rd_data),
        .count (count)
    );

    assign wm_eff   = (rx_wm == '0) ? CW'(1) : rx_wm;
    assign rff_flag = port_en && (count >= wm_eff);
    assign rx_irq   = rff_flag && rx_irq_en;

    // R11: disabling the port clears both flags on the next cycle
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!rff_flag && !rfs_flag));

    // R7: the flag cannot rise on a cycle that only reads
    a_r7_no_rise_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rd_en && !push && !rff_flag && $stable(rx_wm)) |=> (!rff_flag || $changed(rx_wm)));
endmodule

// File: tb/tb_srx_slot_ctrl.sv
`timescale 1ns/1ps
module tb_srx_slot_ctrl;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_en = 1'b0;
    logic          net_mode = 1'b0;
    logic [3:0]    rx_wm = 4'd1;
    logic          rx_irq_en = 1'b0;
    logic          bclk = 1'b1;
    logic          fsync = 1'b0;
    logic          sdin = 1'b0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic          rfs_flag, rff_flag, rx_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    srx_slot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .net_mode(net_mode),
        .rx_wm(rx_wm), .rx_irq_en(rx_irq_en), .bclk(bclk), .fsync(fsync),
        .sdin(sdin), .rd_en(rd_en), .rd_data(rd_data), .rfs_flag(rfs_flag),
        .rff_flag(rff_flag), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic fs, input logic d);
        @(negedge clk); bclk = 1'b1; fsync = fs; sdin = d;
        idle(2);
        bclk = 1'b0;
        idle(2);
        fsync = 1'b0;
    endtask

    task automatic send_word(input logic fs, input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) send_bit((i == W - 1) ? fs : 1'b0, w[i]);
        idle(1);
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        idle(1);
    endtask

    task automatic cycle_port();
        @(negedge clk); port_en = 1'b0;
        idle(2);
        port_en = 1'b1;
        idle(1);
    endtask

    function automatic logic [W-1:0] pat(input int k, input int j);
        return W'((k * 16'h1111 + j * 16'h0357 + 16'h0A0B) & 16'hFFFF);
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] last;
        idle(3);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 rfs", rfs_flag, 0);
        chk("R1 rff", rff_flag, 0);
        chk("R1 irq", rx_irq, 0);
        rst_n = 1'b1;
        port_en = 1'b1;
        idle(2);

        // R3: bits with no open slot are ignored in normal mode
        send_word(1'b0, 16'h1234);
        chk("R3 idle bits ignored rff", rff_flag, 0);
        // R2: MSB-first capture
        send_word(1'b1, 16'hA5C3);
        chk("R2 rff after word", rff_flag, 1);
        chk("R5 rfs after sync", rfs_flag, 1);
        do_read();
        chk("R2 data", rd_data, 16'hA5C3);
        chk("R7 rff after read", rff_flag, 0);
        // R9: empty read keeps value
        do_read();
        chk("R9 empty read", rd_data, 16'hA5C3);
        send_word(1'b1, 16'h0F0F);
        do_read();
        chk("R9 no underflow", rd_data, 16'h0F0F);
        chk("R9 empty after", rff_flag, 0);

        // R6/R7/R8/R10 sweep of the watermark
        for (int k = 0; k <= 9; k++) begin
            int eff;
            eff = (k == 0) ? 1 : k;
            cycle_port();
            rx_wm = 4'(k);
            rx_irq_en = k[0];
            for (int j = 1; j <= 8; j++) begin
                send_word(1'b1, pat(k, j));
                chk($sformatf("R6 rff wm=%0d n=%0d", k, j), rff_flag, (j >= eff) ? 1 : 0);
                chk($sformatf("R10 irq wm=%0d n=%0d", k, j), rx_irq, ((j >= eff) && k[0]) ? 1 : 0);
            end
            send_word(1'b1, pat(k, 9));
            chk($sformatf("R8 full held wm=%0d", k), rff_flag, (8 >= eff) ? 1 : 0);
            for (int j = 1; j <= 8; j++) begin
                do_read();
                chk($sformatf("R8 data wm=%0d ix=%0d", k, j), rd_data, pat(k, j));
                chk($sformatf("R7 rff wm=%0d left=%0d", k, 8 - j), rff_flag, ((8 - j) >= eff) ? 1 : 0);
            end
            do_read();
            chk($sformatf("R8 dropped word absent wm=%0d", k), rd_data, pat(k, 8));
        end
        rx_irq_en = 1'b0;

        // R3: normal mode, a sync-less slot after a capture is not stored
        cycle_port();
        rx_wm = 4'd2;
        send_word(1'b1, 16'h1111);
        send_word(1'b0, 16'h2222);
        chk("R3 second slot ignored", rff_flag, 0);
        do_read();
        chk("R3 captured slot", rd_data, 16'h1111);

        // R4/R5: network mode
        cycle_port();
        net_mode = 1'b1;
        rx_wm = 4'd4;
        send_word(1'b1, 16'hC001);
        chk("R5 rfs slot0", rfs_flag, 1);
        send_bit(1'b0, 1'b0);
        chk("R5 rfs cleared slot1", rfs_flag, 0);
        for (int i = W - 2; i >= 0; i--) send_bit(1'b0, 1'b0);
        idle(1);
        send_word(1'b0, 16'hC003);
        send_word(1'b0, 16'hC004);
        chk("R4 four slots stored", rff_flag, 1);
        do_read(); chk("R4 slot0", rd_data, 16'hC001);
        do_read(); chk("R4 slot1", rd_data, 16'h0000);
        do_read(); chk("R4 slot2", rd_data, 16'hC003);
        do_read(); chk("R4 slot3", rd_data, 16'hC004);

        // R12: sync mid-slot restarts
        rx_wm = 4'd2;
        for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b1);
        send_word(1'b1, 16'h5A5A);
        chk("R12 one word only", rff_flag, 0);
        do_read();
        chk("R12 resync word", rd_data, 16'h5A5A);

        // R11: disable flushes and clears flags
        rx_wm = 4'd1;
        send_word(1'b1, 16'h7777);
        send_word(1'b0, 16'h8888);
        last = rd_data;
        @(negedge clk); port_en = 1'b0;
        idle(2);
        chk("R11 rff cleared", rff_flag, 0);
        chk("R11 rfs cleared", rfs_flag, 0);
        port_en = 1'b1;
        idle(2);
        chk("R11 fifo flushed", rff_flag, 0);
        do_read();
        chk("R11 rd_data kept", rd_data, 32'(last));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule